// File: doc/BRIEF.md
# Flash Status Flag Generator

This block lives inside an embedded flash controller and builds the status byte that the bus sees while an internal program or erase cycle runs. It counts command write pulses, decides whether a decoded command is accepted, follows the busy cycle, checks sector protection, and times the window in which further sector-erase commands may join a pending erase. On each status read that hits flash while the block is busy, it returns a byte with four flags: a data-polling bit, a toggle bit, a sticky error bit and an erase-window bit. When the block is idle, or when the read does not hit flash, the byte read from the array is passed through.

The command decoder and a cycle-time model sit around the block. The decoder supplies one strobe per decoded command, with an operation code, the target sector and bit 7 of the byte to program. The cycle-time model reports completion, failure or timeout. The status read port is a plain strobe. The block answers every read one cycle later with a valid pulse. It cannot be stalled, so there is no back-pressure: a consumer must take each result in the cycle it is valid.

Top module: `flash_stat_gen`

## Requirements
- R1: After reset `busy` and `stat_vld` are 0. A read (`rd_stb`) returns `arr_data` on `stat_byte` one cycle later, with `stat_vld` high, whenever the block is idle or `rd_fsel` is 0.
- R2: A command strobe clears the write-pulse count. A program (`cmd_op`=1) is accepted only after at least 4 write pulses. A sector erase (`cmd_op`=2) or a bulk erase (`cmd_op`=3) is accepted only after at least 6. A command with fewer pulses is ignored.
- R3: While a program cycle is busy, a flash read returns bit 7 equal to the inverse of `prog_d7`. After `cyc_done` the block is idle and reads return the array byte.
- R4: During the erase window, an erase run or a fake-busy period, bit 7 of the status byte reads 0.
- R5: Bit 6 is cleared when a busy cycle starts from idle, so the first flash read returns 0. Each busy flash read inverts it, and reads with `rd_fsel`=0 leave it unchanged.
- R6: A program aimed at a sector whose `sect_prot` bit is 1 is ignored, and `busy` stays 0.
- R7: An erase whose selected sectors are all protected performs no erase. It holds `busy` for FAKE_US·CLK_MHZ cycles regardless of `cyc_done`, then returns to idle.
- R8: `cyc_fail` or `cyc_tmo` during a program or erase run sets bit 5 and holds `busy`. Later commands and `cyc_done` are ignored until a flash-reset command (`cmd_op`=4) returns the block to idle with bit 5 clear.
- R9: A sector erase opens a window of WIN_US·CLK_MHZ cycles in which bit 3 reads 0. When the window expires, or when a further accepted sector erase adds its sector, the erase starts and bit 3 reads 1.
- R10: A bulk erase selects every sector and starts at once with no window, so bit 3 reads 1.
- Status byte layout: bit 7 polling, bit 6 toggle, bit 5 error, bit 3 erase window; bits 4, 2, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_pulse | input | 1 | One bus write pulse of a command sequence |
| cmd_stb | input | 1 | Decoded command strobe |
| cmd_op | input | 3 | 1 program, 2 sector erase, 3 bulk erase, 4 flash reset |
| cmd_sect | input | $clog2(SECT_N) | Sector index of the target address |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| sect_prot | input | SECT_N | Per-sector protection, 1 = protected |
| cyc_done | input | 1 | Cycle-time model: internal cycle completed |
| cyc_fail | input | 1 | Cycle-time model: program/erase failure |
| cyc_tmo | input | 1 | Cycle-time model: cycle timeout |
| rd_stb | input | 1 | Status/array read strobe |
| rd_fsel | input | 1 | Read address falls in a flash sector |
| arr_data | input | 8 | Array byte at the read address |
| stat_byte | output | 8 | Read result |
| stat_vld | output | 1 | `stat_byte` valid, one cycle after `rd_stb` |
| busy | output | 1 | Internal cycle, window, fake-busy or error hold active |

## Verification
A read strobed at one rising edge yields `stat_byte` and `stat_vld` after the next edge. The bench therefore drives every input on falling edges, pushes the expected byte when it drives the read, and pops and compares it on the following falling edge when `stat_vld` is seen. `busy` changes on the edge that accepts a command or completion pulse, and is checked on the falling edge right after. The erase window and fake-busy periods end a fixed number of cycles after acceptance, so their reads are placed well inside or well past those bounds rather than on the boundary edge.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_BERASE = 3'd3,
    OP_RESET  = 3'd4
  } fsg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_EWIN,
    ST_ERASE,
    ST_FAKE,
    ST_FAIL
  } fsg_state_e;
endpackage

// File: rtl/fsg_pulse_cnt.sv
module fsg_pulse_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pulse,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear)
      cnt <= '0;
    else if (wr_pulse && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fsg_timer.sv
module fsg_timer #(
  parameter int CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int TW = $clog2(CYC + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(CYC);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= LOAD_VAL;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == TW'(1)) && !load;
endmodule

// File: rtl/fsg_seq.sv
module fsg_seq
  import fsg_pkg::*;
#(
  parameter int SECT_N       = 8,
  parameter int SECT_W       = 3,
  parameter int PCNT_W       = 3,
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  fsg_op_e           op,
  input  logic [SECT_W-1:0] sect,
  input  logic              prog_d7,
  input  logic [SECT_N-1:0] prot,
  input  logic [PCNT_W-1:0] pcnt,
  input  logic              cyc_done,
  input  logic              cyc_fail,
  input  logic              cyc_tmo,
  input  logic              win_exp,
  input  logic              fake_exp,
  output fsg_state_e        st,
  output logic              win_load,
  output logic              fake_load,
  output logic              new_cycle,
  output logic              busy,
  output logic              poll_bit,
  output logic              err_bit,
  output logic              ewin_bit
);
  localparam logic [SECT_N-1:0] ALL_SECT = {SECT_N{1'b1}};

  fsg_state_e        st_n;
  logic [SECT_N-1:0] mask, mask_n, sect_oh, er_set;
  logic              d7, d7_n, is_erase, is_erase_n;
  logic              prog_ok, serase_ok, berase_ok, do_reset;

  assign sect_oh   = SECT_N'(1) << sect;
  assign prog_ok   = cmd_stb && op == OP_PROG   && pcnt >= PCNT_W'(PROG_PULSES);
  assign serase_ok = cmd_stb && op == OP_SERASE && pcnt >= PCNT_W'(ERASE_PULSES);
  assign berase_ok = cmd_stb && op == OP_BERASE && pcnt >= PCNT_W'(ERASE_PULSES);
  assign do_reset  = cmd_stb && op == OP_RESET;

  always_comb begin
    st_n       = st;
    mask_n     = mask;
    d7_n       = d7;
    is_erase_n = is_erase;
    win_load   = 1'b0;
    fake_load  = 1'b0;
    new_cycle  = 1'b0;
    er_set     = mask;
    unique case (st)
      ST_IDLE: begin
        if (prog_ok && !prot[sect]) begin
          st_n       = ST_PROG;
          d7_n       = prog_d7;
          is_erase_n = 1'b0;
          new_cycle  = 1'b1;
        end else if (serase_ok) begin
          st_n       = ST_EWIN;
          mask_n     = sect_oh;
          is_erase_n = 1'b1;
          win_load   = 1'b1;
          new_cycle  = 1'b1;
        end else if (berase_ok) begin
          er_set     = ALL_SECT;
          mask_n     = ALL_SECT;
          is_erase_n = 1'b1;
          new_cycle  = 1'b1;
          if (|(ALL_SECT & ~prot)) st_n = ST_ERASE;
          else begin
            st_n      = ST_FAKE;
            fake_load = 1'b1;
          end
        end
      end
      ST_EWIN: begin
        er_set = serase_ok ? (mask | sect_oh) : mask;
        if (serase_ok || win_exp) begin
          mask_n = er_set;
          if (|(er_set & ~prot)) st_n = ST_ERASE;
          else begin
            st_n      = ST_FAKE;
            fake_load = 1'b1;
          end
        end
      end
      ST_PROG, ST_ERASE: begin
        if (cyc_fail || cyc_tmo) st_n = ST_FAIL;
        else if (cyc_done)       st_n = ST_IDLE;
      end
      ST_FAKE: if (fake_exp) st_n = ST_IDLE;
      ST_FAIL: if (do_reset) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mask     <= '0;
      d7       <= 1'b0;
      is_erase <= 1'b0;
    end else begin
      st       <= st_n;
      mask     <= mask_n;
      d7       <= d7_n;
      is_erase <= is_erase_n;
    end
  end

  assign busy     = st != ST_IDLE;
  assign poll_bit = (st == ST_PROG || (st == ST_FAIL && !is_erase)) ? ~d7 : 1'b0;
  assign err_bit  = st == ST_FAIL;
  assign ewin_bit = st != ST_EWIN;
endmodule

// File: rtl/fsg_stat_mux.sv
module fsg_stat_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       rd_fsel,
  input  logic [7:0] arr_data,
  input  logic       busy,
  input  logic       new_cycle,
  input  logic       poll_bit,
  input  logic       err_bit,
  input  logic       ewin_bit,
  output logic [7:0] stat_byte,
  output logic       stat_vld
);
  logic       tog;
  logic       show;
  logic [7:0] flags;

  assign show  = busy && rd_fsel;
  assign flags = {poll_bit, tog, err_bit, 1'b0, ewin_bit, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_byte <= '0;
      stat_vld  <= 1'b0;
      tog       <= 1'b0;
    end else begin
      stat_vld <= rd_stb;
      if (rd_stb) stat_byte <= show ? flags : arr_data;
      if (new_cycle)          tog <= 1'b0;
      else if (rd_stb && show) tog <= ~tog;
    end
  end
endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import fsg_pkg::*;
#(
  parameter int SECT_N       = 8,
  parameter int CLK_MHZ      = 250,
  parameter int WIN_US       = 120,
  parameter int FAKE_US      = 100,
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_pulse,
  input  logic                      cmd_stb,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(SECT_N)-1:0] cmd_sect,
  input  logic                      prog_d7,
  input  logic [SECT_N-1:0]         sect_prot,
  input  logic                      cyc_done,
  input  logic                      cyc_fail,
  input  logic                      cyc_tmo,
  input  logic                      rd_stb,
  input  logic                      rd_fsel,
  input  logic [7:0]                arr_data,
  output logic [7:0]                stat_byte,
  output logic                      stat_vld,
  output logic                      busy
);
  localparam int SECT_W   = $clog2(SECT_N);
  localparam int PCNT_W   = $clog2(ERASE_PULSES + 1);
  localparam int WIN_CYC  = CLK_MHZ * WIN_US;
  localparam int FAKE_CYC = CLK_MHZ * FAKE_US;

  fsg_state_e        st_w;
  logic [PCNT_W-1:0] pcnt_w;
  logic win_load, fake_load, win_exp, fake_exp, new_cycle;
  logic poll_bit, err_bit, ewin_bit;

  fsg_pulse_cnt #(.CNT_W(PCNT_W)) u_pcnt (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .clear(cmd_stb), .cnt(pcnt_w)
  );

  fsg_timer #(.CYC(WIN_CYC)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .load(win_load), .expire(win_exp)
  );

  fsg_timer #(.CYC(FAKE_CYC)) u_fake_tmr (
    .clk(clk), .rst_n(rst_n), .load(fake_load), .expire(fake_exp)
  );

  fsg_seq #(
    .SECT_N(SECT_N), .SECT_W(SECT_W), .PCNT_W(PCNT_W),
    .PROG_PULSES(PROG_PULSES), .ERASE_PULSES(ERASE_PULSES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .op(fsg_op_e'(cmd_op)),
    .sect(cmd_sect), .prog_d7(prog_d7), .prot(sect_prot), .pcnt(pcnt_w),
    .cyc_done(cyc_done), .cyc_fail(cyc_fail), .cyc_tmo(cyc_tmo),
    .win_exp(win_exp), .fake_exp(fake_exp), .st(st_w),
    .win_load(win_load), .fake_load(fake_load), .new_cycle(new_cycle),
    .busy(busy), .poll_bit(poll_bit), .err_bit(err_bit), .ewin_bit(ewin_bit)
  );

  fsg_stat_mux u_mux (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_fsel(rd_fsel),
    .arr_data(arr_data), .busy(busy), .new_cycle(new_cycle),
    .poll_bit(poll_bit), .err_bit(err_bit), .ewin_bit(ewin_bit),
    .stat_byte(stat_byte), .stat_vld(stat_vld)
  );
endmodule

// File: rtl/flash_stat_gen_chk.sv
module flash_stat_gen_chk
  import fsg_pkg::*;
#(
  parameter int SECT_N      = 8,
  parameter int SECT_W      = 3,
  parameter int PCNT_W      = 3,
  parameter int PROG_PULSES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_stb,
  input logic [2:0]        cmd_op,
  input logic [SECT_W-1:0] cmd_sect,
  input logic [SECT_N-1:0] sect_prot,
  input logic              rd_stb,
  input logic              rd_fsel,
  input logic [7:0]        arr_data,
  input logic [7:0]        stat_byte,
  input logic              stat_vld,
  input logic              busy,
  input fsg_state_e        st,
  input logic [PCNT_W-1:0] pcnt
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(busy && rd_fsel)) |=> (stat_vld && stat_byte == $past(arr_data))); // R1

  AST_SHORT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cmd_stb && cmd_op == 3'd1 && pcnt < PCNT_W'(PROG_PULSES)) |=> !busy); // R2

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_fsel && (st == ST_EWIN || st == ST_ERASE || st == ST_FAKE)) |=> !stat_byte[7]); // R4

  AST_PROT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cmd_stb && cmd_op == 3'd1 && sect_prot[cmd_sect]) |=> !busy); // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAIL && !(cmd_stb && cmd_op == 3'd4)) |=> (st == ST_FAIL && busy)); // R8

  AST_ERR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_fsel && st == ST_FAIL) |=> stat_byte[5]); // R8

  AST_EWIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_fsel && st == ST_EWIN) |=> !stat_byte[3]); // R9
endmodule

bind flash_stat_gen flash_stat_gen_chk #(
  .SECT_N(SECT_N), .SECT_W(SECT_W), .PCNT_W(PCNT_W), .PROG_PULSES(PROG_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
  .cmd_sect(cmd_sect), .sect_prot(sect_prot), .rd_stb(rd_stb),
  .rd_fsel(rd_fsel), .arr_data(arr_data), .stat_byte(stat_byte),
  .stat_vld(stat_vld), .busy(busy), .st(st_w), .pcnt(pcnt_w)
);

// File: tb/flash_stat_gen_tb.sv
`timescale 1ns/1ps
module flash_stat_gen_tb;
  localparam int SECT_N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_pulse = 1'b0, cmd_stb = 1'b0, prog_d7 = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_sect = 2'd0;
  logic [SECT_N-1:0] sect_prot = '0;
  logic       cyc_done = 1'b0, cyc_fail = 1'b0, cyc_tmo = 1'b0;
  logic       rd_stb = 1'b0, rd_fsel = 1'b0;
  logic [7:0] arr_data = 8'h00;
  logic [7:0] stat_byte;
  logic       stat_vld, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  flash_stat_gen #(
    .SECT_N(SECT_N), .CLK_MHZ(1), .WIN_US(40), .FAKE_US(20)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_sect(cmd_sect), .prog_d7(prog_d7),
    .sect_prot(sect_prot), .cyc_done(cyc_done), .cyc_fail(cyc_fail),
    .cyc_tmo(cyc_tmo), .rd_stb(rd_stb), .rd_fsel(rd_fsel),
    .arr_data(arr_data), .stat_byte(stat_byte), .stat_vld(stat_vld),
    .busy(busy)
  );

  task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected byte for each valid result
  always @(negedge clk) begin
    if (rst_n && stat_vld) begin
      if (q_exp.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected result: actual %02h expected none", stat_byte);
      end else begin
        check_val(stat_byte, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] sect, input logic d7, input int pulses);
    for (int i = 0; i < pulses; i++) begin
      @(negedge clk) wr_pulse = 1'b1;
      @(negedge clk) wr_pulse = 1'b0;
    end
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_sect = sect; prog_d7 = d7;
    @(negedge clk);
    cmd_stb = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic rd(input logic fsel, input logic [7:0] arr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_stb = 1'b1; rd_fsel = fsel; arr_data = arr;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0; rd_fsel = 1'b0;
  endtask

  task automatic pulse_done(); @(negedge clk) cyc_done = 1'b1; @(negedge clk) cyc_done = 1'b0; endtask
  task automatic pulse_fail(); @(negedge clk) cyc_fail = 1'b1; @(negedge clk) cyc_fail = 1'b0; endtask
  task automatic pulse_tmo();  @(negedge clk) cyc_tmo  = 1'b1; @(negedge clk) cyc_tmo  = 1'b0; endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    check_val({7'd0, busy}, 8'd0, "R1 reset busy");
    check_val({7'd0, stat_vld}, 8'd0, "R1 reset stat_vld");
    rst_n = 1'b1;
    idle(2);
    rd(1'b1, 8'h5A, 8'h5A, "R1 idle read passes array");

    // R2: too few pulses for a program
    cmd(3'd1, 2'd0, 1'b1, 3);
    check_val({7'd0, busy}, 8'd0, "R2 program with 3 pulses ignored");

    // R3/R5: program cycle
    cmd(3'd1, 2'd0, 1'b1, 4);
    check_val({7'd0, busy}, 8'd1, "R3 program accepted");
    rd(1'b1, 8'hFF, 8'h08, "R3 inverted bit7, R5 first toggle 0");
    rd(1'b1, 8'hFF, 8'h48, "R5 toggle inverts");
    rd(1'b0, 8'h33, 8'h33, "R1 non-flash read while busy");
    rd(1'b1, 8'hFF, 8'h08, "R5 non-flash read left toggle");
    pulse_done();
    check_val({7'd0, busy}, 8'd0, "R3 done clears busy");
    rd(1'b1, 8'h81, 8'h81, "R3 true value after done");

    cmd(3'd1, 2'd1, 1'b0, 4);
    rd(1'b1, 8'h00, 8'h88, "R3 bit7 of 0 inverted, R5 toggle cleared");
    pulse_done();

    // R6: protected program
    sect_prot = 4'b0010;
    cmd(3'd1, 2'd1, 1'b0, 5);
    check_val({7'd0, busy}, 8'd0, "R6 protected program ignored");
    rd(1'b1, 8'h11, 8'h11, "R6 reads unaffected");

    // R2: erase needs 6 pulses
    cmd(3'd2, 2'd2, 1'b0, 5);
    check_val({7'd0, busy}, 8'd0, "R2 erase with 5 pulses ignored");

    // R9/R4: sector erase window
    cmd(3'd2, 2'd2, 1'b0, 6);
    check_val({7'd0, busy}, 8'd1, "R9 sector erase opens window");
    rd(1'b1, 8'hFF, 8'h00, "R9 window bit3 0, R4 bit7 0");
    rd(1'b1, 8'hFF, 8'h40, "R5 toggle in window");
    idle(20);
    rd(1'b1, 8'hFF, 8'h00, "R9 window still open");
    idle(30);
    rd(1'b1, 8'hFF, 8'h48, "R9 window expired, R4 erase bit7 0");
    pulse_done();
    check_val({7'd0, busy}, 8'd0, "R9 erase done");

    // R9: second sector erase closes window
    cmd(3'd2, 2'd0, 1'b0, 6);
    rd(1'b1, 8'hFF, 8'h00, "R9 first window");
    cmd(3'd2, 2'd3, 1'b0, 6);
    rd(1'b1, 8'hFF, 8'h48, "R9 second sector erase starts erase");
    pulse_done();

    // R7: all selected protected via window
    cmd(3'd2, 2'd1, 1'b0, 6);
    idle(45);
    check_val({7'd0, busy}, 8'd1, "R7 fake busy after window");
    rd(1'b1, 8'hFF, 8'h08, "R7 fake busy bit7 0");
    pulse_done();
    check_val({7'd0, busy}, 8'd1, "R7 done ignored in fake busy");
    idle(25);
    check_val({7'd0, busy}, 8'd0, "R7 fake busy ends");

    // R10/R7: bulk erase with all protected
    sect_prot = 4'hF;
    cmd(3'd3, 2'd0, 1'b0, 6);
    check_val({7'd0, busy}, 8'd1, "R7 bulk all protected busy");
    rd(1'b1, 8'hFF, 8'h08, "R7 bulk fake status");
    idle(25);
    check_val({7'd0, busy}, 8'd0, "R7 bulk fake ends");

    // R10: bulk erase with some unprotected
    sect_prot = 4'b0010;
    cmd(3'd3, 2'd0, 1'b0, 6);
    rd(1'b1, 8'hFF, 8'h08, "R10 bulk starts with no window");
    idle(50);
    check_val({7'd0, busy}, 8'd1, "R10 bulk waits for done");
    pulse_done();

    // R8: program failure
    sect_prot = 4'b0000;
    cmd(3'd1, 2'd0, 1'b1, 4);
    pulse_fail();
    rd(1'b1, 8'hFF, 8'h28, "R8 error bit set");
    pulse_done();
    check_val({7'd0, busy}, 8'd1, "R8 done ignored in error");
    cmd(3'd1, 2'd2, 1'b0, 4);
    rd(1'b1, 8'hFF, 8'h68, "R8 error held, new program ignored");
    cmd(3'd4, 2'd0, 1'b0, 0);
    check_val({7'd0, busy}, 8'd0, "R8 flash reset clears");
    cmd(3'd1, 2'd0, 1'b0, 4);
    rd(1'b1, 8'hFF, 8'h88, "R8 error cleared after reset");
    pulse_done();

    // R8: erase timeout
    cmd(3'd3, 2'd0, 1'b0, 6);
    rd(1'b1, 8'hFF, 8'h08, "R8 bulk running");
    pulse_tmo();
    rd(1'b1, 8'hFF, 8'h68, "R8 timeout sets error");
    cmd(3'd4, 2'd0, 1'b0, 0);
    check_val({7'd0, busy}, 8'd0, "R8 reset after timeout");

    idle(3);
    check_val(8'(q_exp.size()), 8'd0, "R1 every read answered");
    finish_run();
  end
endmodule